// File: doc/BRIEF.md
# SONET Frame Detector FSM

This block watches one deinterleaved channel of a bit-interleaved serial link, one bit per valid strobe, for the 32-bit framing word made of two A1 bytes followed by two A2 bytes. A small state machine decides whether the link is in frame and drives an active-low loss-of-frame flag. When no framing word turns up for a programmable number of clock cycles, it sends a single-cycle roll pulse to the demultiplexer so that the next channel is tried. It also outputs the byte position inside the frame, counted from the byte that follows the framing word.

The machine has three states. ST_SEARCH scans every bit position and runs the search timer. ST_CONFIRM has seen one framing word and waits one full frame for the second. ST_INFRAME checks the last bit of each frame at the expected place and counts consecutive misses. The transitions are: search-hit (ST_SEARCH to ST_CONFIRM, realigning the position counter), confirm-hit (ST_CONFIRM to ST_INFRAME), confirm-miss (ST_CONFIRM to ST_SEARCH), inframe-hit (stay, miss count cleared), inframe-miss (stay, miss count incremented), inframe-drop (fourth consecutive miss, back to ST_SEARCH), search-timeout (stay in ST_SEARCH, roll pulse, timer restarted) and frame-reset (any state to ST_SEARCH).

Top module: `sonet_frame_detector`

## Requirements
- R1: While frame_rst_n is low the block is in ST_SEARCH with lof_n = 0, roll = 0 and frame_pos = 0.
- R2: The framing word is 0xF6F62828 (A1 = 0xF6, A2 = 0x28), received most significant bit first. Only an exact match counts, and a match in ST_SEARCH sets frame_pos to 0 for the byte that follows the word. frame_pos then advances once every 8 valid bits and wraps after FRAME_BYTES - 1.
- R3: lof_n goes high in the cycle after a second framing word ends exactly FRAME_BYTES*8 valid bits after the first.
- R4: If the word is missing at the expected position in ST_CONFIRM, the machine returns to ST_SEARCH with lof_n still low. A later word is then treated as a new first hit.
- R5: In ST_INFRAME, up to three consecutive misses keep lof_n high. The fourth consecutive miss drives lof_n low in the next cycle.
- R6: A hit at the expected position clears the consecutive-miss count, so after it four new consecutive misses are needed to lose frame.
- R7: In ST_SEARCH with no match, roll pulses high for exactly one cycle after every TIMEOUT_CYCLES clock cycles. The first pulse is visible TIMEOUT_CYCLES cycles after frame reset is released.
- R8: roll stays low in ST_CONFIRM and ST_INFRAME, however long no bits arrive.
- R9: Cycles with bit_valid low are ignored: bit_in is not shifted in, and frame_pos and the frame check do not advance.
- R10: Pulling frame_rst_n low while in frame forces ST_SEARCH, lof_n low and frame_pos to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| frame_rst_n | input | 1 | Active-low asynchronous frame reset |
| bit_in | input | 1 | Channel data bit, most significant bit of each byte first |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| lof_n | output | 1 | High when in frame, low while searching or confirming |
| roll | output | 1 | One-cycle request to rotate the demultiplexer channels |
| frame_pos | output | $clog2(FRAME_BYTES) | Byte index within the frame, 0 = byte after the framing word |

## Verification
The assertions assume TIMEOUT_CYCLES is at least 2, FRAME_BYTES is at least 4, and frame_rst_n is the only thing that moves the machine other than valid bits and the timer. The stimulus therefore uses a short configuration: 16-byte frames and a 200-cycle timeout. It builds every frame from exact framing words and zero filler bytes, so that no false match can occur at a shifted bit offset. Idle gaps toggle bit_in while bit_valid is low, to show that these bits are dropped. A sweep over all 32 single-bit corruptions of the framing word shows that none of them is taken for a hit.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_INFRAME = 2'd2
    } sfd_state_e;

    localparam logic [7:0]  SYNC_HI   = 8'hF6;
    localparam logic [7:0]  SYNC_LO   = 8'h28;
    localparam logic [31:0] SYNC_WORD = {SYNC_HI, SYNC_HI, SYNC_LO, SYNC_LO};
endpackage

// File: rtl/sfd_word_match.sv
module sfd_word_match #(
    parameter int          W       = 32,
    parameter logic [31:0] PATTERN = 32'hF6F62828
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    output logic hit
);
    logic [W-2:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else if (bit_valid)
            hist <= {hist[W-3:0], bit_in};
    end

    // the incoming bit completes the window in the same cycle
    always_comb hit = bit_valid && ({hist, bit_in} == PATTERN[W-1:0]);
endmodule

// File: rtl/sfd_pos_counter.sv
module sfd_pos_counter #(
    parameter  int FRAME_BYTES = 9720,
    localparam int PW          = $clog2(FRAME_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          realign,
    output logic [PW-1:0] byte_pos,
    output logic          at_check
);
    localparam logic [PW-1:0] LAST_BYTE = PW'(FRAME_BYTES - 1);

    logic [2:0] bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            byte_pos <= '0;
        end else if (realign) begin
            bit_idx  <= '0;
            byte_pos <= '0;
        end else if (bit_valid) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7)
                byte_pos <= (byte_pos == LAST_BYTE) ? '0 : byte_pos + 1'b1;
        end
    end

    // last bit of the last byte: where the next framing word must end
    always_comb at_check = bit_valid && (bit_idx == 3'd7) && (byte_pos == LAST_BYTE);

    a_r9_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !realign) |=> $stable(byte_pos));
    a_r2_realign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (byte_pos == '0));
endmodule

// File: rtl/sfd_search_timer.sv
module sfd_search_timer #(
    parameter  int TIMEOUT_CYCLES = 311040,
    localparam int TW             = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] ticks;

    always_comb expire = run && (ticks == LAST_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ticks <= '0;
        else if (!run || expire)
            ticks <= '0;
        else
            ticks <= ticks + 1'b1;
    end

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (ticks == '0));
endmodule

// File: rtl/sonet_frame_detector.sv
module sonet_frame_detector
    import sfd_pkg::*;
#(
    parameter  int FRAME_BYTES    = 9720,
    parameter  int TIMEOUT_CYCLES = 311040,
    parameter  int MISS_LIMIT     = 4,
    localparam int POS_W          = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             frame_rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    output logic             lof_n,
    output logic             roll,
    output logic [POS_W-1:0] frame_pos
);
    localparam int            MW        = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    sfd_state_e    state, state_nx;
    logic [MW-1:0] miss_cnt, miss_nx;
    logic          hit, at_check, realign, timer_run, expire;

    sfd_word_match #(.W(32), .PATTERN(SYNC_WORD)) u_match (
        .clk(clk), .rst_n(frame_rst_n), .bit_in(bit_in),
        .bit_valid(bit_valid), .hit(hit)
    );

    sfd_pos_counter #(.FRAME_BYTES(FRAME_BYTES)) u_pos (
        .clk(clk), .rst_n(frame_rst_n), .bit_valid(bit_valid),
        .realign(realign), .byte_pos(frame_pos), .at_check(at_check)
    );

    sfd_search_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(frame_rst_n), .run(timer_run), .expire(expire)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        miss_nx  = miss_cnt;
        realign  = 1'b0;
        unique case (state)
            ST_SEARCH: begin
                if (hit) begin
                    state_nx = ST_CONFIRM;
                    realign  = 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (at_check)
                    state_nx = hit ? ST_INFRAME : ST_SEARCH;
            end
            ST_INFRAME: begin
                if (at_check) begin
                    if (hit) begin
                        miss_nx = '0;
                    end else if (miss_cnt == MISS_LAST) begin
                        state_nx = ST_SEARCH;
                        miss_nx  = '0;
                    end else begin
                        miss_nx = miss_cnt + 1'b1;
                    end
                end
            end
            default: state_nx = ST_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge frame_rst_n) begin
        if (!frame_rst_n) begin
            state    <= ST_SEARCH;
            miss_cnt <= '0;
            roll     <= 1'b0;
        end else begin
            state    <= state_nx;
            miss_cnt <= miss_nx;
            roll     <= expire;
        end
    end

    // outputs
    always_comb begin
        lof_n     = (state == ST_INFRAME);
        timer_run = (state == ST_SEARCH) && !hit;
    end

    a_r7_roll_pulse: assert property (@(posedge clk) disable iff (!frame_rst_n)
        roll |=> !roll);
    a_r8_roll_in_search: assert property (@(posedge clk) disable iff (!frame_rst_n)
        roll |-> (state == ST_SEARCH));
    a_r3_lock_on_hit: assert property (@(posedge clk) disable iff (!frame_rst_n)
        $rose(lof_n) |-> $past(at_check && hit));
    a_r5_drop_on_miss: assert property (@(posedge clk) disable iff (!frame_rst_n)
        $fell(lof_n) |-> ($past(miss_cnt) == MISS_LAST && $past(at_check && !hit)));
    a_r6_miss_clear: assert property (@(posedge clk) disable iff (!frame_rst_n)
        (state == ST_INFRAME && at_check && hit) |=> (miss_cnt == '0));
endmodule

// File: tb/sim_sonet_frame_detector.sv
module sim_sonet_frame_detector;
    localparam int FB   = 16;
    localparam int TO   = 200;
    localparam int PW   = $clog2(FB);
    localparam logic [31:0] SYNC = 32'hF6F62828;

    logic          clk = 1'b0;
    logic          frame_rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_valid = 1'b0;
    logic          lof_n, roll;
    logic [PW-1:0] frame_pos;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sonet_frame_detector #(.FRAME_BYTES(FB), .TIMEOUT_CYCLES(TO), .MISS_LIMIT(4)) u0 (
        .clk(clk), .frame_rst_n(frame_rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .lof_n(lof_n), .roll(roll), .frame_pos(frame_pos)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in    = b;
        bit_valid = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic fill(input int nbytes);
        for (int i = 0; i < nbytes; i++) send_byte(8'h00);
    endtask

    // closes the last driven bit and leaves inputs idle for sampling
    task automatic settle();
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = ~bit_in;
        end
    endtask

    task automatic pulse_reset(input bit do_check);
        @(negedge clk);
        bit_valid   = 1'b0;
        frame_rst_n = 1'b0;
        @(negedge clk);
        if (do_check) begin
            check("R1 lof_n in reset", lof_n, 0);
            check("R1 roll in reset", roll, 0);
            check("R1 frame_pos in reset", frame_pos, 0);
        end
        frame_rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int rolls;
        int bad;
        int p0;

        // R1: reset state
        repeat (2) @(negedge clk);
        pulse_reset(1'b1);

        // R2: every single-bit corruption of the word is rejected
        bad = 0;
        for (int k = 0; k < 32; k++) begin
            pulse_reset(1'b0);
            send_word(SYNC ^ (32'h1 << k));
            fill(FB - 4);
            send_word(SYNC);
            settle();
            n_checks++;
            if (lof_n !== 1'b0) begin
                bad++;
                n_fails++;
                $display("FAIL R2 corrupt bit %0d actual=%0d expected=0", k, lof_n);
            end
        end

        // R2: first hit realigns frame_pos
        pulse_reset(1'b0);
        send_word(SYNC);
        settle();
        check("R2 lof_n after first hit", lof_n, 0);
        check("R2 frame_pos after hit", frame_pos, 0);
        fill(3);
        settle();
        check("R2 frame_pos after 3 bytes", frame_pos, 3);

        // R9: idle cycles with toggling data are dropped
        p0 = frame_pos;
        idle(7);
        check("R9 frame_pos held over gap", frame_pos, p0);
        fill(FB - 4 - 3);
        idle(5);
        send_word(SYNC);
        settle();
        check("R3 R9 lof_n after second hit", lof_n, 1);
        check("R2 frame_pos wraps to 0", frame_pos, 0);

        // R8: no roll while in frame
        rolls = 0;
        for (int i = 0; i < 2 * TO; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            if (roll) rolls++;
        end
        check("R8 rolls while in frame", rolls, 0);
        check("R8 lof_n held", lof_n, 1);

        // R5 / R6: miss counting
        for (int m = 0; m < 3; m++) fill(FB);
        settle();
        check("R5 lof_n after 3 misses", lof_n, 1);
        fill(FB - 4);
        send_word(SYNC);
        for (int m = 0; m < 3; m++) fill(FB);
        settle();
        check("R6 lof_n after hit then 3 misses", lof_n, 1);
        fill(FB);
        settle();
        check("R5 lof_n after 4th miss", lof_n, 0);

        // R4: miss during confirmation
        send_word(SYNC);
        fill(FB);
        settle();
        check("R4 lof_n after confirm miss", lof_n, 0);
        send_word(SYNC);
        settle();
        check("R4 lof_n after new first hit", lof_n, 0);
        fill(FB - 4);
        send_word(SYNC);
        settle();
        check("R4 lof_n after relock", lof_n, 1);

        // R10: reset while in frame
        fill(5);
        pulse_reset(1'b1);
        @(negedge clk);
        check("R10 lof_n after reset", lof_n, 0);
        check("R10 frame_pos after reset", frame_pos, 0);

        // R7: timeout rolls
        pulse_reset(1'b0);
        bad   = 0;
        rolls = 0;
        for (int i = 1; i <= 3 * TO; i++) begin
            @(negedge clk);
            if (roll) rolls++;
            if (roll !== ((i % TO) == 0)) bad++;
        end
        check("R7 roll cadence mismatches", bad, 0);
        check("R7 roll count", rolls, 3);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule